// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked host and an external asynchronous static RAM of 128K words by 8 bits. The host presents one read or one write at a time on a valid/ready port. The controller turns each request into a timed sequence on the memory's address, chip-enable, output-enable and write-enable pins. It drives the data pins through a split out/in/enable path that feeds a tri-state pad outside the block.

All timing comes from nanosecond limits given as parameters. These are turned into clock counts by rounding up against the clock period, with a floor of one clock. A write is framed by chip enable and write enable falling and rising together, with output enable held high. The block turns on its own data drivers only after the memory's outputs have had time to release. It turns them off on the edge that ends the write. A read holds chip enable and output enable low with write enable high. It captures the data pins on the edge that closes the access wait and then raises a one-cycle valid strobe. Between requests chip enable stays high, so the memory rests in standby.

Top module: `sram_ctrl`

## Requirements
- R1: After reset, chip enable, output enable and write enable are all high (inactive), the data drivers are off, ready is high and read-valid is low.
- R2: Chip enable is high in every cycle in which no access is in progress, that is, whenever ready is high.
- R3: A read holds chip enable low, output enable low and write enable high for the read wait (1 clock at the default parameters). The data drivers stay off, and the memory address equals the requested address and does not change while chip enable is low.
- R4: Read data is registered on the clock edge that ends the read wait. Read-valid is high for exactly one cycle after that edge, with the captured byte on the read-data output.
- R5: A write holds output enable high while write enable and chip enable are low together for the write-low count (2 clocks at the default parameters). Chip enable and write enable then rise on the same edge.
- R6: The data drivers are off in the first cycle of a write. They turn on only after the output-release count has elapsed (1 clock by default). They turn off on the same edge on which write enable rises.
- R7: The driven data equals the requested write byte and is present for at least the data-setup count (1 clock by default) before the edge that ends the write.
- R8: Ready is low for the whole of every access. A request is accepted only on an edge where ready and valid are both high.
- R9: The data drivers are never on while output enable is low, or in the cycle right after output enable was low.
- R10: A read of any address returns the byte most recently written there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request valid |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 17 | Word address |
| req_wdata_i | input | 8 | Write byte |
| req_ready_o | output | 1 | Idle, request may be accepted |
| rdata_o | output | 8 | Captured read byte |
| rvalid_o | output | 1 | One-cycle read data strobe |
| sram_addr_o | output | 17 | Memory address pins |
| sram_ce_n_o | output | 1 | Chip enable, active low |
| sram_oe_n_o | output | 1 | Output enable, active low |
| sram_we_n_o | output | 1 | Write enable, active low |
| sram_dq_o | output | 8 | Data to the pad |
| sram_dq_i | input | 8 | Data from the pad |
| sram_dq_oe_o | output | 1 | Pad driver enable |

## Verification
A wrong sequencer state or counter shows up at the pins within one clock. It appears as a strobe that falls or rises one edge off, as drivers turned on in the first write cycle or while output enable is low, or as ready rising early. The memory model in the bench flags each of these as a pulse-width, setup or contention fault in that same cycle. A bad capture edge or a bad address register shows up only later, as a mismatched byte when the location is read back. The bench therefore mixes directed strobe-shape checks with random read-after-write traffic.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } sram_st_e;

  // ceil(ns / clk_ns), at least one clock
  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned RD_CYC     = 1,
  parameter int unsigned HZ_CYC     = 1,
  parameter int unsigned WE_LOW_CYC = 2,
  parameter int unsigned CNT_W      = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic req_we_i,
  output logic ready_o,
  output logic accept_o,
  output logic capture_o,
  output logic ce_n_o,
  output logic oe_n_o,
  output logic we_n_o,
  output logic drv_en_o
);

  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WR_LAST = CNT_W'(WE_LOW_CYC - 1);
  localparam logic [CNT_W-1:0] DRV_AT  = CNT_W'(HZ_CYC);

  sram_st_e         state_q;
  logic [CNT_W-1:0] cnt_q;

  assign ready_o   = (state_q == ST_IDLE);
  assign accept_o  = ready_o & req_valid_i;
  assign capture_o = (state_q == ST_READ) && (cnt_q == RD_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      ce_n_o   <= 1'b1;
      oe_n_o   <= 1'b1;
      we_n_o   <= 1'b1;
      drv_en_o <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept_o) begin
            cnt_q  <= '0;
            ce_n_o <= 1'b0;
            if (req_we_i) begin
              state_q <= ST_WRITE;
              we_n_o  <= 1'b0;
            end else begin
              state_q <= ST_READ;
              oe_n_o  <= 1'b0;
            end
          end
        end
        ST_READ: begin
          if (cnt_q == RD_LAST) begin
            state_q <= ST_IDLE;
            ce_n_o  <= 1'b1;
            oe_n_o  <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_WRITE: begin
          if (cnt_q == WR_LAST) begin
            state_q  <= ST_IDLE;
            ce_n_o   <= 1'b1;
            we_n_o   <= 1'b1;
            drv_en_o <= 1'b0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
            // memory outputs released once the high-Z count has run out
            if ((cnt_q + 1'b1) >= DRV_AT) drv_en_o <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R5
  wr_oe_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_n_o |-> oe_n_o);
  // R5
  wr_needs_ce_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_n_o |-> !ce_n_o);
  // R6
  drv_not_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(we_n_o) |-> !drv_en_o);
  // R6
  drv_off_at_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_n_o) |-> !drv_en_o);
  // R2
  idle_standby_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> ce_n_o);
  // R8
  busy_not_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_n_o |-> !ready_o);

endmodule

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              capture_i,
  input  logic              drv_en_i,
  input  logic              ce_n_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);

  logic [DATA_W-1:0] wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      wdata_q <= '0;
    end else if (accept_i) begin
      addr_o  <= req_addr_i;
      wdata_q <= req_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= capture_i;
      if (capture_i) rdata_o <= dq_i;
    end
  end

  assign dq_o    = wdata_q;
  assign dq_oe_o = drv_en_i;

  // R3
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_n_i && $past(!ce_n_i)) |-> $stable(addr_o));
  // R4
  rvalid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 17,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CLK_NS    = 10,
  parameter int unsigned T_AA_NS   = 10,
  parameter int unsigned T_DOE_NS  = 5,
  parameter int unsigned T_HZOE_NS = 5,
  parameter int unsigned T_PWE_NS  = 8,
  parameter int unsigned T_AW_NS   = 8,
  parameter int unsigned T_SD_NS   = 5,
  parameter int unsigned T_WC_NS   = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic              sram_ce_n_o,
  output logic              sram_oe_n_o,
  output logic              sram_we_n_o,
  output logic [DATA_W-1:0] sram_dq_o,
  input  logic [DATA_W-1:0] sram_dq_i,
  output logic              sram_dq_oe_o
);

  localparam int unsigned RD_CYC = umax(ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_DOE_NS, CLK_NS));
  localparam int unsigned HZ_CYC = ns_to_cyc(T_HZOE_NS, CLK_NS);
  localparam int unsigned SD_CYC = ns_to_cyc(T_SD_NS, CLK_NS);
  // one idle cycle follows every write, so the cycle floor is WC-1
  localparam int unsigned WE_LOW_CYC =
    umax(umax(ns_to_cyc(T_PWE_NS, CLK_NS), ns_to_cyc(T_AW_NS, CLK_NS)),
         umax(HZ_CYC + SD_CYC, ns_to_cyc(T_WC_NS, CLK_NS) - 1));
  localparam int unsigned CNT_W = $clog2(umax(RD_CYC, WE_LOW_CYC) + 1);

  logic accept, capture, drv_en;

  sram_ctrl_seq #(
    .RD_CYC    (RD_CYC),
    .HZ_CYC    (HZ_CYC),
    .WE_LOW_CYC(WE_LOW_CYC),
    .CNT_W     (CNT_W)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .req_we_i   (req_we_i),
    .ready_o    (req_ready_o),
    .accept_o   (accept),
    .capture_o  (capture),
    .ce_n_o     (sram_ce_n_o),
    .oe_n_o     (sram_oe_n_o),
    .we_n_o     (sram_we_n_o),
    .drv_en_o   (drv_en)
  );

  sram_ctrl_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .req_addr_i (req_addr_i),
    .req_wdata_i(req_wdata_i),
    .capture_i  (capture),
    .drv_en_i   (drv_en),
    .ce_n_i     (sram_ce_n_o),
    .dq_i       (sram_dq_i),
    .addr_o     (sram_addr_o),
    .dq_o       (sram_dq_o),
    .dq_oe_o    (sram_dq_oe_o),
    .rdata_o    (rdata_o),
    .rvalid_o   (rvalid_o)
  );

  // R9
  no_contention_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_dq_oe_o |-> (sram_oe_n_o && $past(sram_oe_n_o)));
  // R3
  rd_no_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_oe_n_o |-> (sram_we_n_o && !sram_dq_oe_o));

endmodule

// File: tb/sram_ctrl_tb.sv
module sram_ctrl_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        ready, rvalid, ce_n, oe_n, we_n, dq_oe;
  logic [7:0]  rdata, dq_o, dq_bus;
  logic [16:0] sram_addr;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  logic [7:0] model_mem [int unsigned];
  logic [7:0] ref_mem   [int unsigned];

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .req_ready_o(ready), .rdata_o(rdata), .rvalid_o(rvalid),
    .sram_addr_o(sram_addr), .sram_ce_n_o(ce_n), .sram_oe_n_o(oe_n),
    .sram_we_n_o(we_n), .sram_dq_o(dq_o), .sram_dq_i(dq_bus),
    .sram_dq_oe_o(dq_oe)
  );

  function automatic logic [7:0] init_val(logic [16:0] a);
    return a[7:0] ^ a[15:8] ^ {7'd0, a[16]};
  endfunction

  function automatic logic [7:0] model_rd(logic [16:0] a);
    return model_mem.exists(a) ? model_mem[a] : init_val(a);
  endfunction

  function automatic logic [7:0] ref_rd(logic [16:0] a);
    return ref_mem.exists(a) ? ref_mem[a] : init_val(a);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural memory and shared bus
  logic mem_drv, mem_drv_prev;
  always_comb begin
    mem_drv = !ce_n && !oe_n && we_n;
    if (mem_drv)    dq_bus = model_rd(sram_addr);
    else if (dq_oe) dq_bus = dq_o;
    else            dq_bus = '0;
  end

  // pin monitor
  bit          wr_prev = 1'b0, dq_oe_prev = 1'b0;
  logic [16:0] addr_prev = '0;
  logic [7:0]  dq_prev = '0;
  int          we_low_cnt = 0, drive_cnt = 0;

  always @(negedge clk) begin
    bit wr_now;
    wr_now = rst_n && !ce_n && !we_n;
    if (rst_n) begin
      if (dq_oe) check(!(mem_drv || mem_drv_prev), "R9 bus contention", 1, 0);
      if (ready && !ce_n) check(0, "R2 ce low while idle", ce_n, 1);
      if (wr_now) begin
        we_low_cnt++;
        if (dq_oe) drive_cnt++;
        if (we_low_cnt == 1) check(!dq_oe, "R6 drivers on in first write cycle", dq_oe, 0);
      end
      if (wr_prev && !wr_now) begin
        check(we_low_cnt >= 2, "R5 write pulse width", we_low_cnt, 2);
        check(drive_cnt >= 1 && dq_oe_prev, "R7 data setup before write end", drive_cnt, 1);
        check(!dq_oe, "R6 drivers still on after write end", dq_oe, 0);
        model_mem[addr_prev] = dq_prev;
        we_low_cnt = 0;
        drive_cnt  = 0;
      end
    end
    mem_drv_prev = mem_drv;
    wr_prev      = wr_now;
    dq_oe_prev   = dq_oe;
    addr_prev    = sram_addr;
    dq_prev      = dq_o;
  end

  task automatic wait_ready();
    while (!ready) @(negedge clk);
  endtask

  task automatic do_write(input logic [16:0] a, input logic [7:0] d);
    wait_ready();
    req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    check(!ce_n && !we_n && oe_n, "R5 write strobes", {ce_n, we_n, oe_n}, 3'b001);
    check(!dq_oe, "R6 drivers off first cycle", dq_oe, 0);
    check(!ready, "R8 ready low during write", ready, 0);
    check(sram_addr == a, "R3 write address", sram_addr, a);
    @(negedge clk);
    check(!we_n && dq_oe && dq_o == d, "R7 driven write data", dq_o, d);
    @(negedge clk);
    check(ce_n && we_n && !dq_oe, "R5 ce and we rise together", {ce_n, we_n, dq_oe}, 3'b110);
    check(ready, "R8 ready after write", ready, 1);
    ref_mem[a] = d;
  endtask

  task automatic do_read(input logic [16:0] a);
    logic [7:0] exp;
    exp = ref_rd(a);
    wait_ready();
    req_valid = 1'b1; req_we = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check(!ce_n && !oe_n && we_n && !dq_oe, "R3 read strobes",
          {ce_n, oe_n, we_n, dq_oe}, 4'b0010);
    check(sram_addr == a, "R3 read address", sram_addr, a);
    check(!ready && !rvalid, "R8 ready low during read", {ready, rvalid}, 0);
    @(negedge clk);
    check(rvalid, "R4 rvalid raised", rvalid, 1);
    check(rdata == exp, "R10 read data", rdata, exp);
    check(ce_n && oe_n, "R2 standby after read", {ce_n, oe_n}, 3);
    @(negedge clk);
    check(!rvalid, "R4 rvalid single cycle", rvalid, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [16:0] a;
    logic [16:0] used [16];
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(ce_n && oe_n && we_n, "R1 strobes high in reset", {ce_n, oe_n, we_n}, 7);
    check(!dq_oe && ready && !rvalid, "R1 drivers off, ready", {dq_oe, ready, rvalid}, 3'b010);
    rst_n = 1'b1;
    @(negedge clk);
    check(ce_n && oe_n && we_n && ready, "R1 idle after reset",
          {ce_n, oe_n, we_n, ready}, 15);

    // directed corners
    do_read(17'h00123);                 // unwritten location
    do_write(17'h00000, 8'hA5);
    do_write(17'h1FFFF, 8'h5A);
    do_read(17'h1FFFF);
    do_read(17'h00000);
    do_write(17'h00000, 8'hFF);         // overwrite, then immediate read
    do_read(17'h00000);
    do_write(17'h0AAAA, 8'h00);
    do_write(17'h0AAAA, 8'h3C);         // back-to-back writes
    do_read(17'h0AAAA);
    // idle gap: standby monitor sees ce high
    repeat (5) @(negedge clk);
    check(ce_n && ready, "R2 standby during idle gap", {ce_n, ready}, 3);

    // random mix over a small address pool so reads hit prior writes
    for (int i = 0; i < 16; i++) used[i] = 17'($urandom);
    for (int i = 0; i < 400; i++) begin
      a = ($urandom % 4 == 0) ? 17'($urandom) : used[$urandom % 16];
      if ($urandom % 2) do_write(a, 8'($urandom));
      else              do_read(a);
      if ($urandom % 5 == 0) repeat ($urandom % 3) @(negedge clk);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule